// File: doc/BRIEF.md
# Data-Processing Execution Unit

This block is the integer execution stage of a 32-bit load/store core. On each valid strobe it takes an operation code, a destination index, a set-flags bit, two operands and the current carry. It returns the 32-bit result and its write-enable in the same cycle. At the next clock edge it updates the negative, zero, carry and overflow flags. The register file, instruction decode, exception handling and the full register-shift barrel shifter are outside the block. The shift carry of a register operand arrives on an input pin.

Operand two is either a register value or an 8-bit constant. The constant is rotated right by twice a 4-bit rotate field. Either operand may be the program counter, and the block then applies the pipeline offset. When the destination index is the program counter, the block leaves the flags alone and asks for a pipeline refill. If set-flags is high, it also asks for the status word to be restored from its saved copy.

The interface is a plain strobe with no back-pressure. The unit accepts one operation on every cycle that has `in_valid` high and never stalls. Cycles with `in_valid` low leave all state unchanged.

Top module: `dpu_exec`

## Requirements
- R1: The op code selects the result. 0 gives A AND B, 1 gives A XOR B, 2 gives A−B, 3 gives B−A, 4 gives A+B, 5 gives A+B+carry_in, 6 gives A−B−(1−carry_in) and 7 gives B−A−(1−carry_in). 8 gives A AND B, 9 gives A XOR B, 10 gives A−B and 11 gives A+B. 12 gives A OR B, 13 gives B, 14 gives A AND NOT B and 15 gives NOT B.
- R2: `result_we` equals `in_valid` for codes 0–7 and 12–15. It is never high for codes 8–11.
- R3: Codes 0, 1, 8, 9 and 12–15 are the logical codes. When they update the flags, N becomes result bit 31, Z is set when the result is zero, C takes the shifter carry and V keeps its old value.
- R4: When code 2 or 10 updates the flags, C is set when B ≤ A unsigned, and V is set on signed overflow of A−B. Code 3 applies the same rules to B−A.
- R5: When code 4, 5 or 11 updates the flags, C is the unsigned carry out of the full sum, including carry_in for code 5. V is set on signed overflow of that sum.
- R6: When code 6 updates the flags, C is set when B+1−carry_in ≤ A, with the left side evaluated at 33 bits. V is set on signed overflow of A−B−(1−carry_in). Code 7 swaps A and B.
- R7: Codes 8–11 update the flags even when `set_flags` is 0. Codes 0–7 and 12–15 update the flags only when `set_flags` is 1.
- R8: For a code that writes a result with destination index 15, the flags are unchanged. `reload_req` is high in the following cycle, and `restore_req` is high in that cycle only if `set_flags` was 1.
- R9: For codes 8–11 with destination index 15, the flags are unchanged. `restore_req` is high in the following cycle and `reload_req` stays low.
- R10: In immediate form, operand B is `imm_byte` zero-extended and rotated right by 2×`imm_rot`. A rotate field of 0 leaves the byte unchanged.
- R11: In immediate form with a non-zero rotate, the shifter carry is bit 31 of the rotated constant. Otherwise it is the `shift_carry` input.
- R12: An operand flagged as the program counter reads `pc_value`. It reads `pc_value`+4 when `reg_shift` is 1 and `imm_form` is 0.
- R13: Flags and request outputs change only on an edge with `in_valid` high. Without a strobe, both requests are low in the next cycle. An active-low synchronous reset clears all flags and requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select |
| set_flags | input | 1 | Request to update flags |
| dest_idx | input | 4 | Destination register index |
| opnd_a | input | 32 | First operand register value |
| opnd_b | input | 32 | Second operand register value (after external shift) |
| a_is_pc | input | 1 | First operand is the program counter |
| b_is_pc | input | 1 | Second operand is the program counter |
| pc_value | input | 32 | Program counter as seen with the normal offset |
| reg_shift | input | 1 | Second operand shifted by a register amount |
| imm_form | input | 1 | Second operand is the rotated constant |
| imm_byte | input | 8 | Constant byte |
| imm_rot | input | 4 | Half of the rotate-right amount |
| carry_in | input | 1 | Current carry flag for chained arithmetic |
| shift_carry | input | 1 | Carry out of the external shifter |
| result | output | 32 | Operation result |
| result_we | output | 1 | Result write-enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| restore_req | output | 1 | Restore status word from saved copy |
| reload_req | output | 1 | Pipeline refill request |

## Verification
The assertions check several properties on every cycle:
- the test and compare codes never raise the write-enable;
- a destination of 15 freezes the flags;
- the logical codes never move V;
- test codes never request a refill;
- idle cycles raise no request;
- a rotate field of zero passes the constant byte and the external carry through unchanged.

The arithmetic carry and overflow values can only be shown by the bench sweeps. These sweeps cover every op code, both carry inputs, the boundary operands and every rotate amount. The bench compares each result with a signed 64-bit reference model. The same holds for the program-counter offset and the exact pairing of restore and reload requests.

// File: rtl/dpu_pkg.sv
package dpu_pkg;

  typedef enum logic [3:0] {
    OP_AND   = 4'h0,
    OP_XOR   = 4'h1,
    OP_SUB   = 4'h2,
    OP_RSUB  = 4'h3,
    OP_ADD   = 4'h4,
    OP_ADDC  = 4'h5,
    OP_SUBC  = 4'h6,
    OP_RSUBC = 4'h7,
    OP_TAND  = 4'h8,
    OP_TXOR  = 4'h9,
    OP_CMP   = 4'hA,
    OP_CMPN  = 4'hB,
    OP_OR    = 4'hC,
    OP_MOVB  = 4'hD,
    OP_ANDN  = 4'hE,
    OP_NOTB  = 4'hF
  } dpu_op_e;

  function automatic logic op_is_test(dpu_op_e o);
    return (o == OP_TAND) || (o == OP_TXOR) || (o == OP_CMP) || (o == OP_CMPN);
  endfunction

  function automatic logic op_is_logic(dpu_op_e o);
    return (o == OP_AND) || (o == OP_XOR) || (o == OP_TAND) || (o == OP_TXOR) ||
           (o == OP_OR) || (o == OP_MOVB) || (o == OP_ANDN) || (o == OP_NOTB);
  endfunction

endpackage

// File: rtl/dpu_operand_sel.sv
module dpu_operand_sel #(
  parameter int DW    = 32,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4,
  parameter int PC_LOOKAHEAD = 4
) (
  input  logic [DW-1:0]    opnd_a,
  input  logic [DW-1:0]    opnd_b,
  input  logic             a_is_pc,
  input  logic             b_is_pc,
  input  logic [DW-1:0]    pc_value,
  input  logic             reg_shift,
  input  logic             imm_form,
  input  logic [IMM_W-1:0] imm_byte,
  input  logic [ROT_W-1:0] imm_rot,
  input  logic             shift_carry,
  output logic [DW-1:0]    op_a,
  output logic [DW-1:0]    op_b,
  output logic             shf_carry
);
  localparam int SHW = $clog2(DW) + 1;

  logic [DW-1:0]  pc_seen;
  logic [DW-1:0]  imm_ext;
  logic [DW-1:0]  imm_rotated;
  logic [SHW-1:0] rot_amt;

  // Register-amount shifts read the PC one fetch later
  assign pc_seen = (reg_shift && !imm_form) ? pc_value + DW'(PC_LOOKAHEAD) : pc_value;

  assign imm_ext = DW'(imm_byte);
  assign rot_amt = SHW'({imm_rot, 1'b0});

  // Per-bit rotate: output bit i takes source bit (i + amount) mod DW
  for (genvar gi = 0; gi < DW; gi++) begin : g_rot
    logic [SHW:0] src_idx;
    always_comb begin
      src_idx = (SHW+1)'(gi) + (SHW+1)'(rot_amt);
      if (src_idx >= (SHW+1)'(DW)) src_idx = src_idx - (SHW+1)'(DW);
    end
    assign imm_rotated[gi] = imm_ext[src_idx[SHW-1:0]];
  end

  assign op_a      = a_is_pc ? pc_seen : opnd_a;
  assign op_b      = imm_form ? imm_rotated : (b_is_pc ? pc_seen : opnd_b);
  assign shf_carry = (imm_form && (imm_rot != '0)) ? imm_rotated[DW-1] : shift_carry;

endmodule

// File: rtl/dpu_arith.sv
module dpu_arith
  import dpu_pkg::*;
#(
  parameter int DW = 32
) (
  input  dpu_op_e       op,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          carry_in,
  output logic [DW-1:0] res,
  output logic          c_arith,
  output logic          v_arith
);
  logic [DW-1:0] x_opnd;
  logic [DW-1:0] y_opnd;
  logic [DW:0]   sum_w;
  logic [DW:0]   subtr_w;
  logic          reverse;

  function automatic logic add_ovf(logic [DW-1:0] p, logic [DW-1:0] q, logic [DW-1:0] s);
    logic [DW-1:0] t;
    t = (p ^ s) & (q ^ s);
    return t[DW-1];
  endfunction

  function automatic logic sub_ovf(logic [DW-1:0] p, logic [DW-1:0] q, logic [DW-1:0] s);
    logic [DW-1:0] t;
    t = (p ^ s) & (~q ^ s);
    return t[DW-1];
  endfunction

  // Reversed subtractions swap minuend and subtrahend
  assign reverse = (op == OP_RSUB) || (op == OP_RSUBC);
  assign x_opnd  = reverse ? op_b : op_a;
  assign y_opnd  = reverse ? op_a : op_b;

  always_comb begin
    res     = '0;
    c_arith = 1'b0;
    v_arith = 1'b0;
    sum_w   = '0;
    subtr_w = '0;
    unique case (op)
      OP_AND, OP_TAND: res = op_a & op_b;
      OP_XOR, OP_TXOR: res = op_a ^ op_b;
      OP_OR:           res = op_a | op_b;
      OP_MOVB:         res = op_b;
      OP_ANDN:         res = op_a & ~op_b;
      OP_NOTB:         res = ~op_b;
      OP_ADD, OP_CMPN, OP_ADDC: begin
        sum_w = {1'b0, op_a} + {1'b0, op_b};
        if (op == OP_ADDC) sum_w = sum_w + (DW+1)'(carry_in);
        res     = sum_w[DW-1:0];
        c_arith = sum_w[DW];
        v_arith = add_ovf(op_a, op_b, sum_w[DW-1:0]);
      end
      OP_SUB, OP_CMP, OP_RSUB: begin
        res     = x_opnd - y_opnd;
        c_arith = (y_opnd <= x_opnd);
        v_arith = sub_ovf(x_opnd, y_opnd, x_opnd - y_opnd);
      end
      OP_SUBC, OP_RSUBC: begin
        subtr_w = {1'b0, y_opnd} + (DW+1)'(1) - (DW+1)'(carry_in);
        res     = x_opnd - subtr_w[DW-1:0];
        c_arith = (subtr_w <= {1'b0, x_opnd});
        v_arith = sub_ovf(x_opnd, y_opnd, x_opnd - subtr_w[DW-1:0]);
      end
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/dpu_flag_ctl.sv
module dpu_flag_ctl #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          is_test,
  input  logic          is_logic,
  input  logic          set_flags,
  input  logic          dest_is_pc,
  input  logic [DW-1:0] res,
  input  logic          c_arith,
  input  logic          v_arith,
  input  logic          shf_carry,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_c,
  output logic          flag_v,
  output logic          restore_req,
  output logic          reload_req
);
  logic upd_flags;
  logic want_restore;
  logic want_reload;

  assign upd_flags    = in_valid && !dest_is_pc && (is_test || set_flags);
  assign want_restore = in_valid && dest_is_pc && (is_test || set_flags);
  assign want_reload  = in_valid && dest_is_pc && !is_test;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_n      <= 1'b0;
      flag_z      <= 1'b0;
      flag_c      <= 1'b0;
      flag_v      <= 1'b0;
      restore_req <= 1'b0;
      reload_req  <= 1'b0;
    end else begin
      restore_req <= want_restore;
      reload_req  <= want_reload;
      if (upd_flags) begin
        flag_n <= res[DW-1];
        flag_z <= (res == '0);
        flag_c <= is_logic ? shf_carry : c_arith;
        if (!is_logic) flag_v <= v_arith;
      end
    end
  end

  AST_PC_DEST_FLAGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dest_is_pc) |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R8

  AST_TEST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_test) |=> !reload_req); // R9

  AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_logic) |=> $stable(flag_v)); // R3

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!restore_req && !reload_req)); // R13

  AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R13

endmodule

// File: rtl/dpu_exec.sv
module dpu_exec
  import dpu_pkg::*;
#(
  parameter int DW     = 32,
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [3:0]       op_code,
  input  logic             set_flags,
  input  logic [IDX_W-1:0] dest_idx,
  input  logic [DW-1:0]    opnd_a,
  input  logic [DW-1:0]    opnd_b,
  input  logic             a_is_pc,
  input  logic             b_is_pc,
  input  logic [DW-1:0]    pc_value,
  input  logic             reg_shift,
  input  logic             imm_form,
  input  logic [IMM_W-1:0] imm_byte,
  input  logic [ROT_W-1:0] imm_rot,
  input  logic             carry_in,
  input  logic             shift_carry,
  output logic [DW-1:0]    result,
  output logic             result_we,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v,
  output logic             restore_req,
  output logic             reload_req
);
  dpu_op_e       op;
  logic [DW-1:0] op_a;
  logic [DW-1:0] op_b;
  logic          shf_carry;
  logic          c_arith;
  logic          v_arith;
  logic          is_test;
  logic          is_logic;
  logic          dest_is_pc;

  assign op         = dpu_op_e'(op_code);
  assign is_test    = op_is_test(op);
  assign is_logic   = op_is_logic(op);
  assign dest_is_pc = (dest_idx == IDX_W'(PC_IDX));
  assign result_we  = in_valid && !is_test;

  dpu_operand_sel #(.DW(DW), .IMM_W(IMM_W), .ROT_W(ROT_W)) i_opsel (
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .a_is_pc     (a_is_pc),
    .b_is_pc     (b_is_pc),
    .pc_value    (pc_value),
    .reg_shift   (reg_shift),
    .imm_form    (imm_form),
    .imm_byte    (imm_byte),
    .imm_rot     (imm_rot),
    .shift_carry (shift_carry),
    .op_a        (op_a),
    .op_b        (op_b),
    .shf_carry   (shf_carry)
  );

  dpu_arith #(.DW(DW)) i_arith (
    .op       (op),
    .op_a     (op_a),
    .op_b     (op_b),
    .carry_in (carry_in),
    .res      (result),
    .c_arith  (c_arith),
    .v_arith  (v_arith)
  );

  dpu_flag_ctl #(.DW(DW)) i_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .is_test     (is_test),
    .is_logic    (is_logic),
    .set_flags   (set_flags),
    .dest_is_pc  (dest_is_pc),
    .res         (result),
    .c_arith     (c_arith),
    .v_arith     (v_arith),
    .shf_carry   (shf_carry),
    .flag_n      (flag_n),
    .flag_z      (flag_z),
    .flag_c      (flag_c),
    .flag_v      (flag_v),
    .restore_req (restore_req),
    .reload_req  (reload_req)
  );

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code[3:2] == 2'b10) |-> !result_we); // R2

  AST_ZERO_ROT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_form && imm_rot == '0) |-> (op_b == DW'(imm_byte) && shf_carry == shift_carry)); // R10

endmodule

// File: tb/test_dpu_exec.sv
module test_dpu_exec;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op_code;
  logic        set_flags;
  logic [3:0]  dest_idx;
  logic [31:0] opnd_a, opnd_b, pc_value;
  logic        a_is_pc, b_is_pc, reg_shift, imm_form;
  logic [7:0]  imm_byte;
  logic [3:0]  imm_rot;
  logic        carry_in, shift_carry;
  logic [31:0] result;
  logic        result_we, flag_n, flag_z, flag_c, flag_v, restore_req, reload_req;

  int vec_cnt = 0;
  int err_cnt = 0;
  logic [3:0] m_flags;   // model {n,z,c,v}

  always #(CLK_PERIOD/2) clk = ~clk;

  dpu_exec i_dpu_exec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .set_flags(set_flags), .dest_idx(dest_idx), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .a_is_pc(a_is_pc), .b_is_pc(b_is_pc), .pc_value(pc_value), .reg_shift(reg_shift),
    .imm_form(imm_form), .imm_byte(imm_byte), .imm_rot(imm_rot), .carry_in(carry_in),
    .shift_carry(shift_carry), .result(result), .result_we(result_we),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .restore_req(restore_req), .reload_req(reload_req)
  );

  function automatic logic ovf(longint d);
    return (d > 64'sd2147483647) || (d < -64'sd2147483648);
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s %s: actual %h expected %h (op %0d a %h b %h cin %0b)",
               rq, what, act, exp, op_code, opnd_a, opnd_b, carry_in);
    end
  endtask

  // Applies the current drive at posedge+P/4, checks comb then registered outputs.
  task automatic run_vec(input string rq);
    logic [31:0] a, b, pcs, r;
    logic        shc, c, v, tst, lgc, upd, d15, exp_rs, exp_rl;
    longint      sa, sb, d;
    longint unsigned w;
    logic [3:0]  nf;
    pcs = (reg_shift && !imm_form) ? pc_value + 32'd4 : pc_value;   // R12
    a = a_is_pc ? pcs : opnd_a;
    if (imm_form) begin                                              // R10
      b = {24'd0, imm_byte};
      for (int k = 0; k < 2 * imm_rot; k++) b = {b[0], b[31:1]};
    end else b = b_is_pc ? pcs : opnd_b;
    shc = (imm_form && imm_rot != 0) ? b[31] : shift_carry;          // R11
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    c = 1'b0; v = 1'b0; r = '0;
    case (op_code)
      4'h0, 4'h8: r = a & b;
      4'h1, 4'h9: r = a ^ b;
      4'hC: r = a | b;
      4'hD: r = b;
      4'hE: r = a & ~b;
      4'hF: r = ~b;
      4'h2, 4'hA: begin r = a - b; c = (b <= a); v = ovf(sa - sb); end
      4'h3: begin r = b - a; c = (a <= b); v = ovf(sb - sa); end
      4'h4, 4'hB, 4'h5: begin
        w = longint'(a) + longint'(b) + ((op_code == 4'h5) ? longint'(carry_in) : 0);
        r = w[31:0]; c = w[32];
        v = ovf(sa + sb + ((op_code == 4'h5) ? longint'(carry_in) : 0));
      end
      4'h6: begin
        d = 1 - longint'(carry_in);
        r = a - b - d[31:0]; c = (longint'(b) + d) <= longint'(a); v = ovf(sa - sb - d);
      end
      default: begin
        d = 1 - longint'(carry_in);
        r = b - a - d[31:0]; c = (longint'(a) + d) <= longint'(b); v = ovf(sb - sa - d);
      end
    endcase
    tst = (op_code >= 4'h8) && (op_code <= 4'hB);
    lgc = !((op_code >= 4'h2 && op_code <= 4'h7) || op_code == 4'hA || op_code == 4'hB);
    d15 = (dest_idx == 4'd15);
    upd = in_valid && !d15 && (tst || set_flags);                    // R7
    exp_rs = in_valid && d15 && (tst || set_flags);                  // R8 R9
    exp_rl = in_valid && d15 && !tst;
    nf = m_flags;
    if (upd) nf = {r[31], r == 0, lgc ? shc : c, lgc ? m_flags[0] : v};
    vec_cnt++;
    #1;
    chk(rq, "result", result, r);
    chk(rq, "result_we (R2)", {31'd0, result_we}, {31'd0, in_valid && !tst});
    @(posedge clk);
    #(CLK_PERIOD/4 - 1);
    chk(rq, "flags nzcv", {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, nf});
    chk(rq, "restore_req", {31'd0, restore_req}, {31'd0, exp_rs});
    chk(rq, "reload_req", {31'd0, reload_req}, {31'd0, exp_rl});
    m_flags = nf;
  endtask

  function automatic string op_tag(input logic [3:0] o);
    case (o)
      4'h2, 4'h3: return "R1,R4";
      4'h4, 4'h5: return "R1,R5";
      4'h6, 4'h7: return "R1,R6";
      4'h8, 4'h9, 4'hA, 4'hB: return "R7,R2";
      default: return "R1,R3";
    endcase
  endfunction

  task automatic clear_drive();
    in_valid = 1'b1; set_flags = 1'b1; dest_idx = 4'd3; a_is_pc = 1'b0; b_is_pc = 1'b0;
    reg_shift = 1'b0; imm_form = 1'b0; imm_byte = '0; imm_rot = '0; pc_value = 32'h0000_1008;
    carry_in = 1'b0; shift_carry = 1'b0; op_code = 4'h0; opnd_a = '0; opnd_b = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    logic [31:0] corners [6];
    corners = '{32'h0, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1, 32'h8000_0001};
    rst_n = 1'b0;
    clear_drive();
    in_valid = 1'b0;
    m_flags = '0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R13: reset state
    vec_cnt++;
    chk("R13", "reset flags", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
    chk("R13", "reset requests", {30'd0, restore_req, reload_req}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/4);

    // Main sweep: R1 R2 R3 R4 R5 R6 R7 over corner operands, both carry-ins, S on/off
    for (int op = 0; op < 16; op++)
      for (int ia = 0; ia < 6; ia++)
        for (int ib = 0; ib < 6; ib++)
          for (int cs = 0; cs < 4; cs++) begin
            clear_drive();
            op_code = 4'(op); opnd_a = corners[ia]; opnd_b = corners[ib];
            carry_in = cs[0]; set_flags = cs[1]; shift_carry = 1'($urandom);
            run_vec(op_tag(4'(op)));
          end

    // Random operands
    for (int n = 0; n < 640; n++) begin
      clear_drive();
      op_code = 4'(n % 16); opnd_a = $urandom; opnd_b = $urandom;
      carry_in = 1'($urandom); set_flags = 1'($urandom); shift_carry = 1'($urandom);
      run_vec(op_tag(4'(n % 16)));
    end

    // Immediate constant: every rotate, R10 and R11
    for (int rt = 0; rt < 16; rt++)
      for (int bp = 0; bp < 4; bp++)
        for (int sc = 0; sc < 2; sc++) begin
          clear_drive();
          op_code = (bp[0]) ? 4'hD : 4'h9; imm_form = 1'b1; imm_rot = 4'(rt);
          imm_byte = (bp == 0) ? 8'h01 : (bp == 1) ? 8'h80 : (bp == 2) ? 8'hFF : 8'h5A;
          shift_carry = sc[0]; opnd_a = 32'h0F0F_F0F0; opnd_b = 32'hDEAD_BEEF;
          run_vec("R10,R11");
        end

    // Program counter operand offset, R12
    for (int m = 0; m < 8; m++) begin
      clear_drive();
      op_code = 4'h4; a_is_pc = 1'b1; b_is_pc = m[2]; reg_shift = m[0]; imm_form = m[1];
      imm_byte = 8'h10; opnd_a = 32'h1111_1111; opnd_b = 32'h0000_0100;
      pc_value = 32'h0000_2000 + 32'(m * 64);
      run_vec("R12");
    end

    // Destination 15: R8 for writing codes, R9 for test codes
    for (int op = 0; op < 16; op++)
      for (int s = 0; s < 2; s++) begin
        clear_drive();
        op_code = 4'(op); dest_idx = 4'd15; set_flags = s[0];
        opnd_a = $urandom; opnd_b = 32'h0; carry_in = 1'($urandom);
        run_vec((op >= 8 && op <= 11) ? "R9" : "R8");
      end

    // Idle cycles leave state and requests alone, R13
    for (int n = 0; n < 16; n++) begin
      clear_drive();
      in_valid = 1'b0; op_code = 4'(n); dest_idx = 4'd15; opnd_a = $urandom; opnd_b = $urandom;
      run_vec("R13");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule